// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects a configurable number of device request lines (eight by default) and one request that cannot be masked. It turns them into a single request with a vector code for a small processor core. Each raw line is first brought into the core clock domain through two flip-flops. A per-line mode bit then selects how the line is treated. In edge mode, a rising sample is latched as pending. In level mode, the line requests for as long as it is held high. A per-line enable bit decides whether the line may take part at all.

The core sees `irq_out` and `vec_out` only after it signals an instruction boundary. Both outputs are held unchanged until the core pulses `ack`. That acknowledge retires the delivered source: an edge-mode pending bit or the latched non-maskable event is cleared by it. A level-mode line is retired only when its device lowers the line. Software programs the enables and modes, and clears pending bits, through three word registers with a one-cycle registered read.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Every request input passes through two clock stages. A level-mode enabled line that rises just before clock edge 1, with `insn_boundary` held high, gives `irq_out` low after edges 1 and 2 and high after edge 3.
- R2: `irq_out` rises only on an edge where `insn_boundary` is high. While `insn_boundary` is low, a waiting request is not presented.
- R3: Register address 0 holds the enable bits, with bit i enabling line i, and resets to 0. A line whose enable bit is 0 never requests, and a rising edge seen while it is disabled is not latched, so its pending bit reads 0.
- R4: A rising edge on `nmi_raw` is latched whatever the enable bits are. It is delivered ahead of every line with vector 0x02, and it is delivered only once per rising edge.
- R5: Register address 1 holds the mode bits, where 1 selects edge mode for line i and the reset value is 0 (level mode). In edge mode, an enabled line whose synchronised sample goes from 0 to 1 sets its pending bit. That bit reads back at bit i of address 2.
- R6: An edge-mode pending bit stays set until one of two things clears it. The first is an `ack` of its own delivery. The second is a write to address 2 with bit i set, which clears that bit; bits written as 0 leave their pending bits unchanged.
- R7: A level-mode line requests while its synchronised input is high and stops when the input falls. It never sets a pending bit.
- R8: When several sources request together, the lowest line index wins.
- R9: The vector for line i is 0x20 + i.
- R10: Once `irq_out` is high, it and `vec_out` stay unchanged until `ack` is sampled high. `irq_out` is low after that edge.
- R11: After reset, `irq_out` is 0, `vec_out` is 0 and all registers read 0. Register reads appear on `reg_rdata` one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | N_LINES | Asynchronous device request lines |
| nmi_raw | input | 1 | Asynchronous non-maskable request |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| ack | input | 1 | Core acknowledges the presented request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 enable, 1 mode, 2 pending) |
| reg_wdata | input | N_LINES | Register write data |
| reg_rdata | output | N_LINES | Registered read data |
| irq_out | output | 1 | Request to the core |
| vec_out | output | VEC_W | Vector code of the delivered source |

## Verification
The enable register is swept through all 256 values while every line is held high in level mode. Each value must produce exactly the vector of its lowest enabled bit, or no request at all, which separates enable gating from priority order. All pairs of simultaneous level requests are tried, which tells the priority order apart from any arrival-order effect. Single edge pulses are tried with the line enabled and with it disabled, then cleared by acknowledge and by a write to the pending register. A non-maskable pulse is tried with every line also requesting, which shows it wins and is not delivered again once acknowledged.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_MODE   = 2'd1;
  localparam logic [1:0] ADDR_PEND   = 2'd2;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_s,
  input  logic [N-1:0] enable,
  input  logic [N-1:0] mode_edge,
  input  logic [N-1:0] w1c,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] req
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= line_s;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic set_i, clr_i;
    assign set_i = mode_edge[i] & enable[i] & line_s[i] & ~prev_q[i];
    assign clr_i = w1c[i] | ack_clr[i] | ~mode_edge[i];

    always_ff @(posedge clk) begin
      if (rst)        pend[i] <= 1'b0;
      else if (set_i) pend[i] <= 1'b1;
      else if (clr_i) pend[i] <= 1'b0;
    end

    assign req[i] = enable[i] & (mode_edge[i] ? pend[i] : line_s[i]);

    // R3: a disabled line cannot acquire a pending bit
    p_masked_no_latch_r3: assert property (@(posedge clk) disable iff (rst)
      (!pend[i] && !enable[i]) |=> !pend[i]);
    // R7: level mode never leaves a pending bit behind
    p_level_no_latch_r7: assert property (@(posedge clk) disable iff (rst)
      !mode_edge[i] |=> !pend[i]);
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R8: the winner is requesting and no lower index is
  p_winner_lowest_r8: assert property (@(posedge clk) disable iff (rst)
    any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_LINES  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int NMI_VEC  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_raw,
  input  logic               nmi_raw,
  input  logic               insn_boundary,
  input  logic               ack,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               irq_out,
  output logic [VEC_W-1:0]   vec_out
);
  import irqc_pkg::*;

  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam int SW    = N_LINES + 1;

  logic [SW-1:0]      sync_q;
  logic [N_LINES-1:0] line_s, enable_q, mode_q, pend, req, w1c, ack_clr;
  logic               nmi_s, nmi_prev_q, nmi_pend_q;
  logic               any;
  logic [IDX_W-1:0]   idx;
  logic               sel_nmi_q;
  logic [IDX_W-1:0]   sel_idx_q;
  logic               take, done;

  irqc_sync #(.W(SW)) u_sync (
    .clk (clk), .rst (rst), .d ({nmi_raw, irq_raw}), .q (sync_q)
  );
  assign line_s = sync_q[N_LINES-1:0];
  assign nmi_s  = sync_q[N_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      mode_q   <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_ENABLE) enable_q <= reg_wdata;
      if (reg_addr == ADDR_MODE)   mode_q   <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADDR_ENABLE: reg_rdata <= enable_q;
        ADDR_MODE:   reg_rdata <= mode_q;
        ADDR_PEND:   reg_rdata <= pend;
        default:     reg_rdata <= '0;
      endcase
    end
  end

  assign w1c  = (reg_we && reg_addr == ADDR_PEND) ? reg_wdata : '0;
  assign take = !irq_out && insn_boundary && (nmi_pend_q || any);
  assign done = irq_out && ack;

  for (genvar i = 0; i < N_LINES; i++) begin : g_ackclr
    assign ack_clr[i] = done && !sel_nmi_q && (sel_idx_q == IDX_W'(i));
  end

  irqc_detect #(.N(N_LINES)) u_detect (
    .clk (clk), .rst (rst), .line_s (line_s), .enable (enable_q),
    .mode_edge (mode_q), .w1c (w1c), .ack_clr (ack_clr),
    .pend (pend), .req (req)
  );

  irqc_prio #(.N(N_LINES), .IDX_W(IDX_W)) u_prio (
    .clk (clk), .rst (rst), .req (req), .any (any), .idx (idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_s;
      if (nmi_s && !nmi_prev_q)  nmi_pend_q <= 1'b1;
      else if (done && sel_nmi_q) nmi_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      vec_out   <= '0;
      sel_nmi_q <= 1'b0;
      sel_idx_q <= '0;
    end else if (take) begin
      irq_out   <= 1'b1;
      sel_nmi_q <= nmi_pend_q;
      sel_idx_q <= idx;
      vec_out   <= nmi_pend_q ? VEC_W'(NMI_VEC)
                              : VEC_W'(VEC_BASE) + VEC_W'(idx);
    end else if (done) begin
      irq_out <= 1'b0;
    end
  end

  // R10: presented request is frozen until acknowledged
  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !ack) |=> (irq_out && $stable(vec_out)));
  // R10: acknowledge withdraws the request
  p_ack_drops_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_out && ack) |=> !irq_out);
  // R2: no new request outside an instruction boundary
  p_boundary_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (!irq_out && !insn_boundary) |=> !irq_out);
  // R4: a latched non-maskable event beats every line
  p_nmi_first_r4: assert property (@(posedge clk) disable iff (rst)
    (!irq_out && insn_boundary && nmi_pend_q) |=>
      (irq_out && vec_out == VEC_W'(NMI_VEC)));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
  localparam int  N = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG = 100000;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] irq_raw = '0, reg_wdata = '0, reg_rdata;
  logic nmi_raw = 1'b0, insn_boundary = 1'b0, ack = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic irq_out;
  logic [7:0] vec_out;
  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk (clk), .rst (rst), .irq_raw (irq_raw), .nmi_raw (nmi_raw),
    .insn_boundary (insn_boundary), .ack (ack), .reg_we (reg_we),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .irq_out (irq_out), .vec_out (vec_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a;
    step();
    d = reg_rdata;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  function automatic logic [7:0] lowest_vec(logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return 8'(32 + i);
    return 8'h00;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] d;
    step(3);
    rst = 1'b0;
    step();
    // R11 reset state
    check("R11 irq", irq_out, 0);
    check("R11 vec", vec_out, 0);
    rd(2'd0, d); check("R11 enable", d, 0);
    rd(2'd1, d); check("R11 mode", d, 0);
    rd(2'd2, d); check("R11 pend", d, 0);

    // R1 synchroniser latency, level mode
    wr(2'd0, 8'h08);
    insn_boundary = 1'b1;
    irq_raw = 8'h08;
    step(); check("R1 edge1", irq_out, 0);
    step(); check("R1 edge2", irq_out, 0);
    step(); check("R1 edge3", irq_out, 1);
    check("R9 vec line3", vec_out, 8'h23);
    // R7 level stops when released; R10 hold while not acked
    insn_boundary = 1'b0;
    irq_raw = '0;
    step(4);
    check("R10 hold irq", irq_out, 1);
    check("R10 hold vec", vec_out, 8'h23);
    pulse_ack();
    check("R10 ack drops", irq_out, 0);
    insn_boundary = 1'b1;
    step(3);
    check("R7 level released", irq_out, 0);
    rd(2'd2, d); check("R7 no pending", d, 0);

    // R3/R8/R9 enable sweep, all lines high in level mode
    irq_raw = 8'hFF;
    insn_boundary = 1'b0;
    step(3);
    for (int m = 0; m < 256; m++) begin
      wr(2'd0, 8'(m));
      insn_boundary = 1'b1;
      step();
      check("R3 sweep irq", irq_out, (m != 0));
      if (m != 0) check("R8 sweep vec", vec_out, lowest_vec(8'(m)));
      insn_boundary = 1'b0;
      if (irq_out) pulse_ack();
    end

    // R8 all pairs of simultaneous requests
    wr(2'd0, 8'hFF);
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        irq_raw = 8'((1 << i) | (1 << j));
        step(3);
        insn_boundary = 1'b1;
        step();
        check("R8 pair irq", irq_out, 1);
        check("R8 pair vec", vec_out, 8'(32 + i));
        insn_boundary = 1'b0;
        irq_raw = '0;
        step(3);
        pulse_ack();
      end
    end

    // R2 no presentation without a boundary
    irq_raw = 8'h40;
    step(6);
    check("R2 gated", irq_out, 0);
    insn_boundary = 1'b1;
    step();
    check("R2 released", irq_out, 1);
    check("R9 vec line6", vec_out, 8'h26);
    insn_boundary = 1'b0;
    irq_raw = '0;
    step(3);
    pulse_ack();

    // R5 edge latch
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h20);
    irq_raw = 8'h20; step(2); irq_raw = '0; step(5);
    rd(2'd2, d); check("R5 pending set", d, 8'h20);
    check("R5 no irq yet", irq_out, 0);
    insn_boundary = 1'b1;
    step();
    check("R5 irq", irq_out, 1);
    check("R9 vec line5", vec_out, 8'h25);
    insn_boundary = 1'b0;
    pulse_ack();
    rd(2'd2, d); check("R6 ack clears", d, 0);
    // R6 write-one-to-clear, zeros leave bits alone
    wr(2'd0, 8'h24);
    irq_raw = 8'h24; step(2); irq_raw = '0; step(5);
    rd(2'd2, d); check("R6 two pending", d, 8'h24);
    wr(2'd2, 8'h20);
    rd(2'd2, d); check("R6 w1c one bit", d, 8'h04);
    wr(2'd2, 8'h04);
    rd(2'd2, d); check("R6 w1c other", d, 0);
    // R3 disabled edge not latched
    wr(2'd0, 8'h00);
    irq_raw = 8'h40; step(2); irq_raw = '0; step(5);
    rd(2'd2, d); check("R3 masked edge", d, 0);
    insn_boundary = 1'b1; step(2);
    check("R3 masked irq", irq_out, 0);
    insn_boundary = 1'b0;

    // R4 NMI with nothing enabled
    nmi_raw = 1'b1; step(2); nmi_raw = 1'b0; step(5);
    insn_boundary = 1'b1; step();
    check("R4 nmi unmasked", irq_out, 1);
    check("R4 nmi vec", vec_out, 8'h02);
    insn_boundary = 1'b0;
    pulse_ack();
    // R4 NMI beats every line, serviced once
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    irq_raw = 8'hFF;
    nmi_raw = 1'b1; step(2); nmi_raw = 1'b0; step(5);
    insn_boundary = 1'b1; step();
    check("R4 nmi wins", vec_out, 8'h02);
    insn_boundary = 1'b0;
    pulse_ack();
    insn_boundary = 1'b1; step();
    check("R4 nmi once", vec_out, 8'h20);
    check("R4 line follows", irq_out, 1);
    insn_boundary = 1'b0;
    irq_raw = '0;
    step(3);
    pulse_ack();
    check("R10 final drop", irq_out, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule